// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the qualified bus-write path of a word-wide flash array and its program/erase controller. Every accepted write event (word address plus data) is checked against a set of multi-write unlock sequences. When a sequence completes, the block issues one operation request to the controller: either a word program or an erase with a mask of the regions to clear. It also keeps a one-way boot-region protection flag, and it runs an identification mode in which reads return fixed codes and the protection state instead of array data.

All sequences open with the same two-write key. A third write then picks the command. The program command takes one more write, which carries the target address and data. The erase family takes a second key pair and a final selector write. The array is split into four regions: boot, two parameter blocks and a main block. A digital override input, standing in for a high-voltage level on the reset pin, lifts the boot protection while it is held.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After `por`, `op_valid`, `op_refused` and `rd_valid` are 0, identification mode is off and the protection flag is clear. A read then returns `rd_id`=0.
- R2: The key is data byte AA to command address 5555, then 55 to 2AAA. Only address bits 14:0 and data bits 7:0 count for matching. A third write of A0 to 5555 followed by any write W makes `op_valid` high with `op_kind`=0 on the cycle after W, carrying W's address and data. `op_mask` then has one bit set for W's region. Mask bit 0 is boot (address bits 16:13 = 0), bit 1 is parameter 1 (=1), bit 2 is parameter 2 (=2), and bit 3 is main (anything else).
- R3: Key, 80 to 5555, key, then 10 to 5555 gives an erase (`op_kind`=1) with mask 1111. If the boot region is protected and the override is low, the mask is 1110.
- R4: Key, 80 to 5555, key, then 30 to a sector address gives an erase decoded from address bits 16:12. A value of 03 gives mask 0010, 05 gives 0100, and 1F gives 1001 (1000 when the boot region is protected). Any other value gives no operation.
- R5: Key, 80, key, then 40 to 5555 sets the protection flag. The flag survives `rst` and is cleared only by `por`.
- R6: A program aimed at the boot region while the flag is set and `hv_override` is low produces a one-cycle `op_refused` and no `op_valid`. With the override high, the program goes ahead.
- R7: Key, then 90 to 5555, enters identification mode. In this mode a read returns `rd_id`=1 and `rd_data` equal to 001F at address 0, 0082 at address 1, the flag on bit 0 at address 2, and 0 elsewhere. `rd_valid` follows `rd_en` by one cycle.
- R8: Identification mode is left either by key then F0 to 5555, or by a single F0 write to any address.
- R9: Any write that does not match the expected step returns the decoder to read mode and produces no operation. A following correct sequence works normally.
- R10: `rst` returns the decoder to read mode, dropping any partial sequence and identification mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to read mode |
| por | input | 1 | Synchronous power-on reset, also clears protection |
| wr_en | input | 1 | Qualified write event |
| wr_addr | input | 17 | Write word address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 17 | Read word address |
| hv_override | input | 1 | Boot-protection override level |
| op_valid | output | 1 | Operation request pulse |
| op_kind | output | 1 | 0 program, 1 erase |
| op_mask | output | 4 | Region mask (bit0 boot, bit1 param 1, bit2 param 2, bit3 main) |
| op_addr | output | 17 | Program address |
| op_data | output | 16 | Program data |
| op_refused | output | 1 | Program refused by protection |
| rd_valid | output | 1 | Read response valid |
| rd_id | output | 1 | Response comes from identification mode |
| rd_data | output | 16 | Identification data |

## Verification
The hardest case to reach is an erase or program hitting the boot region after protection has been set. Reaching it needs the full six-write protection sequence first, followed by another complete sequence, with the override held at each level in turn. The stimulus therefore sets the flag once and then replays program, chip erase and main-sector erase with and without the override. It then applies `rst` to show that the flag survives, and `por` to show that it is cleared. Mismatch recovery is driven by breaking sequences at several steps and then completing a clean sequence.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

    localparam int CMD_AW = 15;
    localparam int NUM_RG = 4;

    localparam int RG_BOOT = 0;
    localparam int RG_P1   = 1;
    localparam int RG_P2   = 2;
    localparam int RG_MAIN = 3;

    localparam logic [CMD_AW-1:0] A_KEY1 = 15'h5555;
    localparam logic [CMD_AW-1:0] A_KEY2 = 15'h2AAA;

    localparam logic [7:0] C_KEY1  = 8'hAA;
    localparam logic [7:0] C_KEY2  = 8'h55;
    localparam logic [7:0] C_PROG  = 8'hA0;
    localparam logic [7:0] C_ERPRE = 8'h80;
    localparam logic [7:0] C_CHIP  = 8'h10;
    localparam logic [7:0] C_SECT  = 8'h30;
    localparam logic [7:0] C_LOCK  = 8'h40;
    localparam logic [7:0] C_IDIN  = 8'h90;
    localparam logic [7:0] C_IDOUT = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_U1, ST_U2, ST_PDATA, ST_E3, ST_E4, ST_E5
    } step_e;

    typedef struct packed {
        logic              key1;
        logic              key2;
        logic [7:0]        code;
        logic [NUM_RG-1:0] prog_mask;
        logic              sect_ok;
        logic [NUM_RG-1:0] sect_mask;
    } wr_class_t;

    function automatic logic [NUM_RG-1:0] onehot_rg(input int idx);
        logic [NUM_RG-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ucd_match.sv
module ucd_match
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BLK_W  = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code,
    output wr_class_t         cls
);
    localparam int RGF_W = ADDR_W - BLK_W;
    localparam int SAF_W = RGF_W + 1;

    logic [RGF_W-1:0] rg_field;
    logic [SAF_W-1:0] sa_field;

    assign rg_field = addr[ADDR_W-1:BLK_W];
    assign sa_field = addr[ADDR_W-1:BLK_W-1];

    always_comb begin
        cls.key1 = (addr[CMD_AW-1:0] == A_KEY1);
        cls.key2 = (addr[CMD_AW-1:0] == A_KEY2);
        cls.code = code;

        if (rg_field == RGF_W'(0))      cls.prog_mask = onehot_rg(RG_BOOT);
        else if (rg_field == RGF_W'(1)) cls.prog_mask = onehot_rg(RG_P1);
        else if (rg_field == RGF_W'(2)) cls.prog_mask = onehot_rg(RG_P2);
        else                            cls.prog_mask = onehot_rg(RG_MAIN);

        cls.sect_ok   = 1'b1;
        if (sa_field == SAF_W'(3))      cls.sect_mask = onehot_rg(RG_P1);
        else if (sa_field == SAF_W'(5)) cls.sect_mask = onehot_rg(RG_P2);
        else if (&sa_field)             cls.sect_mask = onehot_rg(RG_MAIN) | onehot_rg(RG_BOOT);
        else begin
            cls.sect_mask = '0;
            cls.sect_ok   = 1'b0;
        end
    end
endmodule

// File: rtl/ucd_seq.sv
module ucd_seq
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  wr_class_t         cls,
    input  logic              hv_override,
    output logic              op_valid,
    output logic              op_kind,
    output logic [NUM_RG-1:0] op_mask,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              op_refused,
    output logic              id_mode,
    output logic              lock_q
);
    step_e             step_q, step_d;
    logic              id_d, lock_d, fire, refuse, kind;
    logic [NUM_RG-1:0] mask;
    logic              boot_ok;

    assign boot_ok = !lock_q || hv_override;

    always_comb begin
        step_d = step_q;
        id_d   = id_mode;
        lock_d = lock_q;
        fire   = 1'b0;
        refuse = 1'b0;
        kind   = 1'b0;
        mask   = '0;
        if (wr_en) begin
            step_d = ST_IDLE;
            id_d   = 1'b0;
            unique case (step_q)
                ST_IDLE: if (cls.key1 && cls.code == C_KEY1) begin
                    step_d = ST_U1; id_d = id_mode;
                end
                ST_U1: if (cls.key2 && cls.code == C_KEY2) begin
                    step_d = ST_U2; id_d = id_mode;
                end
                ST_U2: if (cls.key1) begin
                    if (cls.code == C_PROG) begin
                        step_d = ST_PDATA; id_d = id_mode;
                    end else if (cls.code == C_ERPRE) begin
                        step_d = ST_E3; id_d = id_mode;
                    end else if (cls.code == C_IDIN) begin
                        id_d = 1'b1;
                    end
                end
                ST_PDATA: begin
                    id_d = id_mode;
                    mask = cls.prog_mask;
                    if (cls.prog_mask[RG_BOOT] && !boot_ok) refuse = 1'b1;
                    else                                   fire   = 1'b1;
                end
                ST_E3: if (cls.key1 && cls.code == C_KEY1) begin
                    step_d = ST_E4; id_d = id_mode;
                end
                ST_E4: if (cls.key2 && cls.code == C_KEY2) begin
                    step_d = ST_E5; id_d = id_mode;
                end
                ST_E5: begin
                    kind = 1'b1;
                    if (cls.key1 && cls.code == C_CHIP) begin
                        id_d = id_mode; fire = 1'b1;
                        mask = {NUM_RG{1'b1}};
                        mask[RG_BOOT] = boot_ok;
                    end else if (cls.code == C_SECT && cls.sect_ok) begin
                        id_d = id_mode; fire = 1'b1;
                        mask = cls.sect_mask;
                        mask[RG_BOOT] = cls.sect_mask[RG_BOOT] && boot_ok;
                    end else if (cls.key1 && cls.code == C_LOCK) begin
                        id_d = id_mode; lock_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por) lock_q <= 1'b0;
        else     lock_q <= lock_d;
    end

    always_ff @(posedge clk) begin
        if (rst || por) begin
            step_q     <= ST_IDLE;
            id_mode    <= 1'b0;
            op_valid   <= 1'b0;
            op_refused <= 1'b0;
            op_kind    <= 1'b0;
            op_mask    <= '0;
            op_addr    <= '0;
            op_data    <= '0;
        end else begin
            step_q     <= step_d;
            id_mode    <= id_d;
            op_valid   <= fire;
            op_refused <= refuse;
            op_kind    <= kind;
            op_mask    <= (fire || refuse) ? mask : '0;
            op_addr    <= wr_addr;
            op_data    <= wr_data;
        end
    end
endmodule

// File: rtl/ucd_idread.sv
module ucd_idread #(
    parameter int          ADDR_W   = 17,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  MFR_CODE = 8'h1F,
    parameter logic [7:0]  DEV_CODE = 8'h82
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              id_mode,
    input  logic              lock_q,
    output logic              rd_valid,
    output logic              rd_id,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] id_word;

    always_comb begin
        unique case (rd_addr)
            ADDR_W'(0): id_word = DATA_W'(MFR_CODE);
            ADDR_W'(1): id_word = DATA_W'(DEV_CODE);
            ADDR_W'(2): id_word = DATA_W'(lock_q);
            default:    id_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_id    <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_id    <= rd_en && id_mode;
            rd_data  <= (rd_en && id_mode) ? id_word : '0;
        end
    end
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              hv_override,
    output logic              op_valid,
    output logic              op_kind,
    output logic [NUM_RG-1:0] op_mask,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              op_refused,
    output logic              rd_valid,
    output logic              rd_id,
    output logic [DATA_W-1:0] rd_data
);
    wr_class_t cls;
    logic      id_mode, lock_q;

    ucd_match #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_match (
        .addr (wr_addr),
        .code (wr_data[7:0]),
        .cls  (cls)
    );

    ucd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk, .rst, .por, .wr_en, .wr_addr, .wr_data,
        .cls, .hv_override,
        .op_valid, .op_kind, .op_mask, .op_addr, .op_data, .op_refused,
        .id_mode, .lock_q
    );

    ucd_idread #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idread (
        .clk, .rst(rst || por), .rd_en, .rd_addr, .id_mode, .lock_q,
        .rd_valid, .rd_id, .rd_data
    );
endmodule

// File: rtl/ucd_checker.sv
module ucd_checker (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       rd_en,
    input logic       hv_override,
    input logic       op_valid,
    input logic       op_kind,
    input logic [3:0] op_mask,
    input logic       op_refused,
    input logic       rd_valid,
    input logic       id_mode,
    input logic       lock_q
);
    p_single_event_r6: assert property (@(posedge clk) disable iff (rst || por)
        $onehot0({op_valid, op_refused}));

    p_prog_onehot_r2: assert property (@(posedge clk) disable iff (rst || por)
        (op_valid && !op_kind) |-> $onehot(op_mask));

    p_boot_guard_r6: assert property (@(posedge clk) disable iff (rst || por)
        (op_valid && op_mask[0]) |-> (!$past(lock_q) || $past(hv_override)));

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (por)
        lock_q |=> lock_q);

    p_rd_follow_r7: assert property (@(posedge clk) disable iff (rst || por)
        rd_en |=> rd_valid);

    p_rst_readmode_r10: assert property (@(posedge clk) disable iff (por)
        rst |=> !id_mode);
endmodule

bind unlock_cmd_decoder ucd_checker i_chk (
    .clk, .rst, .por, .rd_en, .hv_override, .op_valid, .op_kind, .op_mask,
    .op_refused, .rd_valid, .id_mode, .lock_q
);

// File: tb/test_unlock_cmd_decoder.sv
`timescale 1ns/1ps
module test_unlock_cmd_decoder;
    logic        clk = 0, rst = 1, por = 1;
    logic        wr_en = 0, rd_en = 0, hv_override = 0;
    logic [16:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic        op_valid, op_kind, op_refused, rd_valid, rd_id;
    logic [3:0]  op_mask;
    logic [16:0] op_addr;
    logic [15:0] op_data, rd_data;

    int checks = 0, failures = 0;

    typedef struct {
        logic        refused;
        logic        kind;
        logic [3:0]  mask;
        logic [16:0] addr;
        logic [15:0] data;
        string       req;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    unlock_cmd_decoder i_unlock_cmd_decoder (.*);

    task automatic wr(input logic [16:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic key();
        wr(17'h1D555, 16'hFFAA);
        wr(17'h0AAAA, 16'h3355);
    endtask

    task automatic expect_op(input logic rf, input logic k, input logic [3:0] m,
                             input logic [16:0] a, input logic [15:0] d, input string r);
        exp_t e;
        e.refused = rf; e.kind = k; e.mask = m; e.addr = a; e.data = d; e.req = r;
        q.push_back(e);
    endtask

    task automatic prog(input logic [16:0] a, input logic [15:0] d);
        key(); wr(17'h05555, 16'h00A0); wr(a, d);
    endtask

    task automatic erase6(input logic [16:0] a, input logic [7:0] c);
        key(); wr(17'h05555, 16'h0080); key(); wr(a, {8'h00, c});
    endtask

    task automatic rd(input logic [16:0] a, input logic eid, input logic [15:0] ed, input string r);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        checks++;
        if (rd_valid !== 1'b1 || rd_id !== eid || (eid && rd_data !== ed)) begin
            failures++;
            $display("FAIL %s read %h: valid=%b id=%b data=%h expected id=%b data=%h",
                     r, a, rd_valid, rd_id, rd_data, eid, ed);
        end
    endtask

    // monitor: pops the scoreboard on every produced event
    always @(negedge clk) begin
        if (!rst && !por && (op_valid || op_refused)) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected op valid=%b refused=%b mask=%b expected none",
                         op_valid, op_refused, op_mask);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (op_refused !== e.refused || op_valid !== !e.refused ||
                    op_mask !== e.mask || (!e.refused && op_kind !== e.kind) ||
                    (!e.refused && !e.kind && (op_addr !== e.addr || op_data !== e.data))) begin
                    failures++;
                    $display("FAIL %s op: ref=%b kind=%b mask=%b addr=%h data=%h expected ref=%b kind=%b mask=%b addr=%h data=%h",
                             e.req, op_refused, op_kind, op_mask, op_addr, op_data,
                             e.refused, e.kind, e.mask, e.addr, e.data);
                end
            end
        end
    end

    task automatic drain(input string r);
        repeat (2) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL %s missing ops: pending=%0d expected 0", r, q.size());
            q.delete();
        end
    endtask

    task automatic pulse(input bit is_por);
        @(negedge clk);
        if (is_por) por = 1; else rst = 1;
        @(negedge clk);
        por = 0; rst = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por = 0; rst = 0;
        // R1 reset state
        checks++;
        if (op_valid !== 0 || op_refused !== 0 || rd_valid !== 0) begin
            failures++;
            $display("FAIL R1 outputs after reset v=%b r=%b rv=%b expected 0", op_valid, op_refused, rd_valid);
        end
        rd(17'h2, 1'b0, 16'h0, "R1");

        // R2 program into each region
        expect_op(0, 0, 4'b0001, 17'h00010, 16'h1234, "R2"); prog(17'h00010, 16'h1234);
        expect_op(0, 0, 4'b0010, 17'h02345, 16'hBEEF, "R2"); prog(17'h02345, 16'hBEEF);
        expect_op(0, 0, 4'b0100, 17'h05000, 16'h0000, "R2"); prog(17'h05000, 16'h0000);
        expect_op(0, 0, 4'b1000, 17'h1F000, 16'hA5A5, "R2"); prog(17'h1F000, 16'hA5A5);
        drain("R2");

        // R3 chip erase, R4 sector erase unlocked
        expect_op(0, 1, 4'b1111, '0, '0, "R3"); erase6(17'h05555, 8'h10);
        expect_op(0, 1, 4'b0010, '0, '0, "R4"); erase6(17'h03123, 8'h30);
        expect_op(0, 1, 4'b0100, '0, '0, "R4"); erase6(17'h05FFF, 8'h30);
        expect_op(0, 1, 4'b1001, '0, '0, "R4"); erase6(17'h1F800, 8'h30);
        erase6(17'h0F000, 8'h30);   // R4 unmatched sector: no op
        drain("R4");

        // R7 identification, R8 single-write exit
        key(); wr(17'h05555, 16'h0090);
        rd(17'h0, 1'b1, 16'h001F, "R7");
        rd(17'h1, 1'b1, 16'h0082, "R7");
        rd(17'h2, 1'b1, 16'h0000, "R7");
        rd(17'h5, 1'b1, 16'h0000, "R7");
        wr(17'h01234, 16'h00F0);
        rd(17'h0, 1'b0, 16'h0, "R8");

        // R5 set protection, visible through identification; R8 keyed exit
        erase6(17'h05555, 8'h40);
        key(); wr(17'h05555, 16'h0090);
        rd(17'h2, 1'b1, 16'h0001, "R5");
        key(); wr(17'h05555, 16'h00F0);
        rd(17'h0, 1'b0, 16'h0, "R8");

        // R6 protection against boot program and erase, override
        expect_op(1, 0, 4'b0001, 17'h00100, 16'h5678, "R6"); prog(17'h00100, 16'h5678);
        expect_op(0, 1, 4'b1110, '0, '0, "R3"); erase6(17'h05555, 8'h10);
        expect_op(0, 1, 4'b1000, '0, '0, "R4"); erase6(17'h1F000, 8'h30);
        hv_override = 1;
        expect_op(0, 0, 4'b0001, 17'h00100, 16'h5678, "R6"); prog(17'h00100, 16'h5678);
        expect_op(0, 1, 4'b1001, '0, '0, "R6"); erase6(17'h1F000, 8'h30);
        hv_override = 0;
        drain("R6");

        // R9 mismatches
        key(); wr(17'h05555, 16'h0077);
        wr(17'h05555, 16'h00A0); wr(17'h00040, 16'h1111);
        wr(17'h15555, 16'h00AA); wr(17'h05555, 16'h00AA); wr(17'h02AAA, 16'h0055);
        key(); wr(17'h05555, 16'h0080); wr(17'h02AAA, 16'h00AA);
        drain("R9");
        expect_op(0, 0, 4'b0010, 17'h03000, 16'h4242, "R9"); prog(17'h03000, 16'h4242);
        drain("R9");

        // R10 reset mid-sequence and in identification mode
        key(); pulse(0); wr(17'h05555, 16'h00A0); wr(17'h1F000, 16'h0001);
        drain("R10");
        key(); wr(17'h05555, 16'h0090);
        pulse(0);
        rd(17'h0, 1'b0, 16'h0, "R10");

        // R5 flag survives rst, cleared by por
        key(); wr(17'h05555, 16'h0090);
        rd(17'h2, 1'b1, 16'h0001, "R5");
        pulse(1);
        key(); wr(17'h05555, 16'h0090);
        rd(17'h2, 1'b1, 16'h0000, "R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule